// File: doc/BRIEF.md
# Signal Interposition Cell Array

This block places a row of identical interposition cells on chosen internal wires of a host processor. Each cell sits between an upstream host signal and its downstream consumer. A separate security control plane drives it. The control plane can watch the wire, cut it, pull it away from its consumer, or replace its value. When that plane is missing, every cell falls back to a plain wire, so the host runs unchanged.

Each cell holds a 3-bit mode register, and the mode register is the cell's state. The states are PASS, TAP, BLOCK, DIVERT and FORCE. Reset puts every cell in PASS. From any state, a configuration write addressed to that cell moves it to the state named by the written code. The move takes place at the next rising clock edge, and every other cell keeps its state. The data path through a cell is combinational. A value set on the injection bus therefore reaches the downstream side in the same cycle.

The number of cells, the width of the signal each cell carries, and the value shown downstream while a wire is cut are all parameters. The default cut value is all zeros.

Top module: `sip_array`

## Requirements
- R1: After reset every cell is in PASS: host_out equals host_in and tap_out is zero for every cell.
- R2: Mode codes 0 (PASS) and the undefined codes 5, 6 and 7 make the cell transparent: its host_out slice equals its host_in slice and its tap_out slice is zero.
- R3: Code 1 (TAP) keeps host_out equal to host_in and also copies the live host_in slice onto the cell's tap_out slice.
- R4: Code 2 (BLOCK) drives the BLOCK_VAL parameter onto the cell's host_out slice. Its tap_out slice is zero.
- R5: Code 3 (DIVERT) drives BLOCK_VAL onto host_out and the live host_in value onto tap_out.
- R6: Code 4 (FORCE) drives the cell's inject_in slice onto host_out in the same cycle. Its tap_out slice is zero.
- R7: While layer_present is low, every cell passes host_in to host_out and drives tap_out to zero, whatever its mode. Stored modes are kept, and they apply again once layer_present returns high.
- R8: A write (cfg_we high, cfg_addr, cfg_code) changes only the mode of cell cfg_addr, at the next rising edge. In the write cycle itself the old mode still governs the outputs. A write whose address is N_CELLS or larger changes no cell. Cell k uses bits [k*SIG_W +: SIG_W] of each bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the mode registers |
| rst_n | input | 1 | Active-low asynchronous reset, sets every mode to PASS |
| layer_present | input | 1 | High when the control plane is attached |
| cfg_we | input | 1 | Mode write strobe |
| cfg_addr | input | $clog2(N_CELLS) | Index of the cell to configure |
| cfg_code | input | 3 | Mode code to store |
| host_in | input | N_CELLS*SIG_W | Upstream host signals |
| inject_in | input | N_CELLS*SIG_W | Replacement values from the control plane |
| host_out | output | N_CELLS*SIG_W | Downstream host signals |
| tap_out | output | N_CELLS*SIG_W | Copies of host signals sent to the control plane |

## Verification
A mode write and live data traffic on the same cell can fall in the same cycle. In that cycle the outputs must still follow the old mode, and the new mode must apply only after the edge. The bench provokes this case by writing FORCE to a cell while that cell's host and injection values differ from each other and from BLOCK_VAL. It samples the cell once before the edge and once after it, and judges both samples against a mode table the bench keeps for itself. The loss of layer_present can also meet a non-transparent mode in the same cycle. The bench drops the layer with every code loaded somewhere in the array, and then checks that the stored modes come back.

// File: rtl/sip_pkg.sv
package sip_pkg;
    typedef enum logic [2:0] {
        MODE_PASS   = 3'd0,
        MODE_TAP    = 3'd1,
        MODE_BLOCK  = 3'd2,
        MODE_DIVERT = 3'd3,
        MODE_FORCE  = 3'd4
    } mode_e;
    localparam int MODE_W = 3;
endpackage

// File: rtl/sip_wr_dec.sv
module sip_wr_dec #(
    parameter int N_CELLS = 12,
    parameter int AW      = 4
) (
    input  logic              we,
    input  logic [AW-1:0]     addr,
    output logic [N_CELLS-1:0] sel
);
    // Addresses at or above N_CELLS match no cell.
    for (genvar i = 0; i < N_CELLS; i++) begin : g_sel
        assign sel[i] = we && (addr == AW'(i));
    end
endmodule

// File: rtl/sip_cell.sv
module sip_cell
    import sip_pkg::*;
#(
    parameter int               SIG_W     = 4,
    parameter logic [SIG_W-1:0] BLOCK_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wr_code,
    input  logic              layer_on,
    input  logic [SIG_W-1:0]  sig_in,
    input  logic [SIG_W-1:0]  inj_in,
    output logic [SIG_W-1:0]  sig_out,
    output logic [SIG_W-1:0]  tap,
    output logic [MODE_W-1:0] mode_q
);
    // State register: the stored mode.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mode_q <= MODE_PASS;
        else if (wr_en)
            mode_q <= wr_code;
    end

    // Output process: combinational path, decoded per state.
    always_comb begin
        sig_out = sig_in;
        tap     = '0;
        if (layer_on) begin
            unique case (mode_q)
                MODE_TAP: begin
                    sig_out = sig_in;
                    tap     = sig_in;
                end
                MODE_BLOCK: begin
                    sig_out = BLOCK_VAL;
                end
                MODE_DIVERT: begin
                    sig_out = BLOCK_VAL;
                    tap     = sig_in;
                end
                MODE_FORCE: begin
                    sig_out = inj_in;
                end
                default: begin
                    sig_out = sig_in;
                end
            endcase
        end
    end
endmodule

// File: rtl/sip_array.sv
module sip_array
    import sip_pkg::*;
#(
    parameter int               N_CELLS   = 12,
    parameter int               SIG_W     = 4,
    parameter logic [SIG_W-1:0] BLOCK_VAL = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       layer_present,
    input  logic                       cfg_we,
    input  logic [$clog2(N_CELLS)-1:0] cfg_addr,
    input  logic [2:0]                 cfg_code,
    input  logic [N_CELLS*SIG_W-1:0]   host_in,
    input  logic [N_CELLS*SIG_W-1:0]   inject_in,
    output logic [N_CELLS*SIG_W-1:0]   host_out,
    output logic [N_CELLS*SIG_W-1:0]   tap_out
);
    localparam int AW = $clog2(N_CELLS);

    logic [N_CELLS-1:0]        cell_sel;
    logic [N_CELLS*MODE_W-1:0] cell_mode;

    sip_wr_dec #(.N_CELLS(N_CELLS), .AW(AW)) u_dec (
        .we   (cfg_we),
        .addr (cfg_addr),
        .sel  (cell_sel)
    );

    for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
        sip_cell #(.SIG_W(SIG_W), .BLOCK_VAL(BLOCK_VAL)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (cell_sel[k]),
            .wr_code  (cfg_code),
            .layer_on (layer_present),
            .sig_in   (host_in[k*SIG_W +: SIG_W]),
            .inj_in   (inject_in[k*SIG_W +: SIG_W]),
            .sig_out  (host_out[k*SIG_W +: SIG_W]),
            .tap      (tap_out[k*SIG_W +: SIG_W]),
            .mode_q   (cell_mode[k*MODE_W +: MODE_W])
        );
    end
endmodule

// File: rtl/sip_array_chk.sv
module sip_array_chk #(
    parameter int               N_CELLS   = 12,
    parameter int               SIG_W     = 4,
    parameter logic [SIG_W-1:0] BLOCK_VAL = '0
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       layer_present,
    input logic                       cfg_we,
    input logic [$clog2(N_CELLS)-1:0] cfg_addr,
    input logic [2:0]                 cfg_code,
    input logic [N_CELLS*SIG_W-1:0]   host_in,
    input logic [N_CELLS*SIG_W-1:0]   inject_in,
    input logic [N_CELLS*SIG_W-1:0]   host_out,
    input logic [N_CELLS*SIG_W-1:0]   tap_out,
    input logic [N_CELLS*3-1:0]       cell_mode
);
    localparam int AW = $clog2(N_CELLS);

    assert_reset_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cell_mode == '0));

    assert_layer_absent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !layer_present |-> (host_out == host_in && tap_out == '0));

    for (genvar k = 0; k < N_CELLS; k++) begin : g_chk
        assert_tap_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (cell_mode[k*3 +: 3] != 3'd1 && cell_mode[k*3 +: 3] != 3'd3)
                |-> tap_out[k*SIG_W +: SIG_W] == '0);
        assert_block_val_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (layer_present && cell_mode[k*3 +: 3] == 3'd2)
                |-> host_out[k*SIG_W +: SIG_W] == BLOCK_VAL);
        assert_divert_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (layer_present && cell_mode[k*3 +: 3] == 3'd3)
                |-> tap_out[k*SIG_W +: SIG_W] == host_in[k*SIG_W +: SIG_W]);
        assert_force_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (layer_present && cell_mode[k*3 +: 3] == 3'd4)
                |-> host_out[k*SIG_W +: SIG_W] == inject_in[k*SIG_W +: SIG_W]);
        assert_cfg_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_addr == AW'(k)) |=> cell_mode[k*3 +: 3] == $past(cfg_code));
        assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !(cfg_we && cfg_addr == AW'(k)) |=> $stable(cell_mode[k*3 +: 3]));
    end
endmodule

bind sip_array sip_array_chk #(
    .N_CELLS(N_CELLS), .SIG_W(SIG_W), .BLOCK_VAL(BLOCK_VAL)
) u_chk (
    .clk(clk), .rst_n(rst_n), .layer_present(layer_present),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_code(cfg_code),
    .host_in(host_in), .inject_in(inject_in),
    .host_out(host_out), .tap_out(tap_out), .cell_mode(cell_mode)
);

// File: tb/sim_sip_array.sv
module sim_sip_array;
    localparam int N  = 12;
    localparam int W  = 4;
    localparam int AW = $clog2(N);
    localparam logic [W-1:0] BV = 4'h5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic layer_present = 1'b1;
    logic cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [2:0] cfg_code = '0;
    logic [N*W-1:0] host_in = '0;
    logic [N*W-1:0] inject_in = '0;
    logic [N*W-1:0] host_out;
    logic [N*W-1:0] tap_out;

    int total = 0;
    int bad = 0;
    int bmode [N];

    always #10 clk = ~clk;

    sip_array #(.N_CELLS(N), .SIG_W(W), .BLOCK_VAL(BV)) u0 (
        .clk(clk), .rst_n(rst_n), .layer_present(layer_present),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_code(cfg_code),
        .host_in(host_in), .inject_in(inject_in),
        .host_out(host_out), .tap_out(tap_out)
    );

    function automatic logic [W-1:0] e_out(int m, logic [W-1:0] h, logic [W-1:0] j, bit lay);
        if (!lay) return h;
        if (m == 2 || m == 3) return BV;
        if (m == 4) return j;
        return h;
    endfunction

    function automatic logic [W-1:0] e_tap(int m, logic [W-1:0] h, bit lay);
        if (lay && (m == 1 || m == 3)) return h;
        return '0;
    endfunction

    function automatic string mtag(int m, bit lay);
        if (!lay) return "R7";
        case (m)
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            default: return "R2";
        endcase
    endfunction

    task automatic set_pattern(int p);
        for (int k = 0; k < N; k++) begin
            host_in[k*W +: W]   = W'((k * 3 + p * 5 + 1) % 16);
            inject_in[k*W +: W] = W'((k * 7 + p * 11 + 2) % 16);
        end
    endtask

    task automatic check_all(string force_tag);
        string t;
        logic [W-1:0] h, j, ao, at, eo, et;
        for (int k = 0; k < N; k++) begin
            h  = host_in[k*W +: W];
            j  = inject_in[k*W +: W];
            ao = host_out[k*W +: W];
            at = tap_out[k*W +: W];
            eo = e_out(bmode[k], h, j, layer_present);
            et = e_tap(bmode[k], h, layer_present);
            t  = (force_tag != "") ? force_tag : mtag(bmode[k], layer_present);
            total += 2;
            if (ao !== eo) begin
                bad++;
                $display("FAIL %s cell %0d host_out act=%h exp=%h", t, k, ao, eo);
            end
            if (at !== et) begin
                bad++;
                $display("FAIL %s cell %0d tap_out act=%h exp=%h", t, k, at, et);
            end
        end
    endtask

    task automatic wr(int a, int c);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = AW'(a);
        cfg_code = 3'(c);
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < N) bmode[a] = c;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < N; k++) bmode[k] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state under several patterns
        for (int p = 0; p < 4; p++) begin
            @(negedge clk);
            set_pattern(p);
            #2 check_all("R1");
        end
        // R2..R7: sweep every code over every cell, layer on and off
        for (int c = 0; c < 8; c++) begin
            for (int k = 0; k < N; k++) wr(k, (k + c) % 8);
            for (int p = 0; p < 5; p++) begin
                @(negedge clk);
                set_pattern(p + c);
                layer_present = 1'b1;
                #2 check_all("");
                layer_present = 1'b0;
                #2 check_all("");
                layer_present = 1'b1;
                #2 check_all("");
            end
        end
        // R8: out-of-range addresses change nothing
        for (int a = N; a < (1 << AW); a++) wr(a, 4);
        @(negedge clk);
        set_pattern(9);
        #2 check_all("R8");
        // R8: write to a cell in the same cycle as live data on it
        for (int k = 0; k < N; k++) wr(k, 0);
        @(negedge clk);
        set_pattern(13);
        cfg_we = 1'b1;
        cfg_addr = AW'(3);
        cfg_code = 3'd4;
        #2 check_all("R8");
        @(negedge clk);
        cfg_we = 1'b0;
        bmode[3] = 4;
        #2 check_all("R8");
        // R8: a second write to another cell leaves cell 3 alone
        wr(7, 3);
        #2 check_all("R8");
        // R7: modes survive a layer drop
        @(negedge clk);
        layer_present = 1'b0;
        #2 check_all("R7");
        @(negedge clk);
        layer_present = 1'b1;
        #2 check_all("R7");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule